// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block drives an open-drain alert line, active low, from a bank of fault inputs that are gated by enable registers written through a simple strobe interface. A fault bit that is enabled and has not yet been reported pulls the line low. The block answers a bus master that broadcasts the alert response address while the alert is pending. It acknowledges the address, then shifts out its own 7-bit address followed by a 1, one bit per transmit slot, and releases the alert if it wins bitwise arbitration.

An I2C slave front end sits next to the block. It supplies single-cycle event strobes: start, stop, address byte received, start of a transmit bit slot (after SCL falls), and an SDA sample (SCL rising). The block returns a request to pull SDA low. A device that loses arbitration stops driving and keeps its alert asserted, so the master can repeat the broadcast. A fault that persists after release does not assert the alert again. A new enabled fault bit does assert it again, and so does a reported bit that clears and then sets again. An optional configuration input also releases the alert whenever this device's own address is received.

Top module: `smb_alert_responder`

## Requirements
- R1: `alert_n` is low exactly when some bit of `fault_in & enables` is not in the reported mask. Fault bit i pairs with bit i%8 of enable register i/8.
- R2: After reset, both enable registers and the reported mask are zero, `alert_n` is 1 and `sda_pull` is 0.
- R3: A pulse on `en_wr[k]` loads `en_wdata` into enable register k, and the new value takes effect from the next cycle.
- R4: An address byte equal to 8'h19 (address 0001100, R/W bit 1) arms a reply only if the alert is pending in that cycle. When armed, `sda_pull` is 1 from the next `ev_tx_slot` (the acknowledge slot) until the following one. When not armed, `sda_pull` stays 0.
- R5: After the acknowledge slot, the block sends `dev_addr` MSB first and then a 1. Each bit is valid from its `ev_tx_slot`, and `sda_pull` is the inverse of the bit.
- R6: If `sda_in` is 0 at an `ev_sda_sample` while the block is sending a 1, the block stops pulling for the rest of the transfer and the alert stays pending.
- R7: If the eighth bit is sampled without a loss, the reported mask takes the active bits, and `alert_n` is 1 from the next cycle unless a new enabled fault bit appears.
- R8: While the fault and enable state are unchanged, a released alert stays released. A newly active bit asserts it again, and so does a reported bit that clears and then sets again.
- R9: With `rel_on_addr` at 1, an address byte whose upper 7 bits equal `dev_addr` (either R/W) releases the alert in the same way as R7. With `rel_on_addr` at 0 it has no effect on the alert.
- R10: `ev_start` or `ev_stop` abandons any reply in progress, and `sda_pull` is 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_in | input | 16 | Fault bits, two groups of 8 |
| en_wr | input | 2 | Write strobe per enable register |
| en_wdata | input | 8 | Enable write data |
| rel_on_addr | input | 1 | Release alert when own address is seen |
| dev_addr | input | 7 | This device's bus address |
| ev_start | input | 1 | Start or repeated start seen |
| ev_stop | input | 1 | Stop seen |
| ev_addr_valid | input | 1 | Address byte received |
| addr_byte | input | 8 | Received address byte, R/W in bit 0 |
| ev_tx_slot | input | 1 | A bit slot begins (SCL fell) |
| ev_sda_sample | input | 1 | SDA sampled (SCL rose) |
| sda_in | input | 1 | Bus SDA level |
| alert_n | output | 1 | Alert line, 0 = asserted |
| sda_pull | output | 1 | Request to pull SDA low |

## Verification
A corrupted reported mask shows up on `alert_n` in the same cycle: either a persistent fault asserts the alert again, or a new fault is hidden. A wrong reply state or shift position shows up at the first transmit slot as a wrong `sda_pull` level, or one slot later as a missed arbitration loss. The bench plays a rival device with a lower address to force a loss on the second address bit. It compares both outputs against its model on every cycle, so a divergence is reported within one clock of its first effect at the ports.

// File: rtl/smbalrt_pkg.sv
package smbalrt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ARMED = 3'd1,
      ST_ACK   = 3'd2,
      ST_SEND  = 3'd3,
      ST_LOST  = 3'd4,
      ST_DONE  = 3'd5
   } ara_st_e;
endpackage

// File: rtl/smbalrt_enable_regs.sv
module smbalrt_enable_regs #(
   parameter int NUM_REGS = 2,
   parameter int REG_W    = 8,
   localparam int FLT_W   = NUM_REGS * REG_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_REGS-1:0] en_wr,
   input  logic [REG_W-1:0]    en_wdata,
   output logic [FLT_W-1:0]    en_vec
);
   logic [REG_W-1:0] en_q [NUM_REGS];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            en_q[g] <= '0;
         else if (en_wr[g])
            en_q[g] <= en_wdata;
      end
      assign en_vec[g*REG_W +: REG_W] = en_q[g];
   end
endmodule

// File: rtl/smbalrt_mask.sv
module smbalrt_mask #(
   parameter int FLT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [FLT_W-1:0] fault_in,
   input  logic [FLT_W-1:0] en_vec,
   input  logic             release_req,
   output logic             pending
);
   logic [FLT_W-1:0] active;
   logic [FLT_W-1:0] rep_q;

   assign active  = fault_in & en_vec;
   assign pending = |(active & ~rep_q);

   always_ff @(posedge clk) begin
      if (!rst_n)
         rep_q <= '0;
      else if (release_req)
         rep_q <= active;
      else
         rep_q <= rep_q & active;
   end
endmodule

// File: rtl/smbalrt_ara_fsm.sv
module smbalrt_ara_fsm
   import smbalrt_pkg::*;
#(
   parameter int              ADDR_W   = 7,
   parameter logic [ADDR_W-1:0] ARA_ADDR = 7'b0001100,
   localparam int             BYTE_W   = ADDR_W + 1,
   localparam int             IDX_W    = $clog2(BYTE_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_start,
   input  logic              ev_stop,
   input  logic              ev_addr_valid,
   input  logic [BYTE_W-1:0] addr_byte,
   input  logic              ev_tx_slot,
   input  logic              ev_sda_sample,
   input  logic              sda_in,
   input  logic              pending,
   input  logic              rel_on_addr,
   input  logic [ADDR_W-1:0] dev_addr,
   output logic              sda_pull,
   output logic              release_req,
   output ara_st_e           st
);
   localparam logic [BYTE_W-1:0] ARA_RD   = {ARA_ADDR, 1'b1};
   localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(BYTE_W - 1);

   ara_st_e           st_q, st_d;
   logic [IDX_W-1:0]  idx_q, idx_d;
   logic [BYTE_W-1:0] sh_q, sh_d;

   always_comb begin
      st_d        = st_q;
      idx_d       = idx_q;
      sh_d        = sh_q;
      release_req = 1'b0;
      if (ev_start || ev_stop) begin
         st_d = ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (ev_addr_valid) begin
                  if (addr_byte == ARA_RD && pending)
                     st_d = ST_ARMED;
                  if (rel_on_addr && addr_byte[BYTE_W-1:1] == dev_addr)
                     release_req = 1'b1;
               end
            end
            ST_ARMED: if (ev_tx_slot) st_d = ST_ACK;
            ST_ACK: begin
               if (ev_tx_slot) begin
                  st_d  = ST_SEND;
                  idx_d = '0;
                  sh_d  = {dev_addr, 1'b1};
               end
            end
            ST_SEND: begin
               if (ev_sda_sample) begin
                  if (sh_q[BYTE_W-1] && !sda_in) begin
                     st_d = ST_LOST;
                  end else if (idx_q == LAST_IDX) begin
                     st_d        = ST_DONE;
                     release_req = 1'b1;
                  end
               end else if (ev_tx_slot) begin
                  idx_d = idx_q + 1'b1;
                  sh_d  = {sh_q[BYTE_W-2:0], 1'b1};
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         idx_q <= '0;
         sh_q  <= '1;
      end else begin
         st_q  <= st_d;
         idx_q <= idx_d;
         sh_q  <= sh_d;
      end
   end

   assign sda_pull = (st_q == ST_ACK) || (st_q == ST_SEND && !sh_q[BYTE_W-1]);
   assign st       = st_q;
endmodule

// File: rtl/smb_alert_responder.sv
module smb_alert_responder
   import smbalrt_pkg::*;
#(
   parameter int                NUM_REGS = 2,
   parameter int                REG_W    = 8,
   parameter int                ADDR_W   = 7,
   parameter logic [ADDR_W-1:0] ARA_ADDR = 7'b0001100,
   localparam int               FLT_W    = NUM_REGS * REG_W,
   localparam int               BYTE_W   = ADDR_W + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [FLT_W-1:0]    fault_in,
   input  logic [NUM_REGS-1:0] en_wr,
   input  logic [REG_W-1:0]    en_wdata,
   input  logic                rel_on_addr,
   input  logic [ADDR_W-1:0]   dev_addr,
   input  logic                ev_start,
   input  logic                ev_stop,
   input  logic                ev_addr_valid,
   input  logic [BYTE_W-1:0]   addr_byte,
   input  logic                ev_tx_slot,
   input  logic                ev_sda_sample,
   input  logic                sda_in,
   output logic                alert_n,
   output logic                sda_pull
);
   if (NUM_REGS < 1 || REG_W < 1 || ADDR_W < 2) begin : g_bad_param
      $error("smb_alert_responder: NUM_REGS, REG_W must be >=1 and ADDR_W >=2");
   end

   logic [FLT_W-1:0] en_vec;
   logic             pending;
   logic             release_req;
   ara_st_e          ara_state;

   smbalrt_enable_regs #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_en (
      .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata), .en_vec(en_vec)
   );

   smbalrt_mask #(.FLT_W(FLT_W)) u_mask (
      .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .en_vec(en_vec),
      .release_req(release_req), .pending(pending)
   );

   smbalrt_ara_fsm #(.ADDR_W(ADDR_W), .ARA_ADDR(ARA_ADDR)) u_fsm (
      .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
      .ev_addr_valid(ev_addr_valid), .addr_byte(addr_byte), .ev_tx_slot(ev_tx_slot),
      .ev_sda_sample(ev_sda_sample), .sda_in(sda_in), .pending(pending),
      .rel_on_addr(rel_on_addr), .dev_addr(dev_addr), .sda_pull(sda_pull),
      .release_req(release_req), .st(ara_state)
   );

   assign alert_n = !pending;
endmodule

// File: rtl/smbalrt_chk.sv
module smbalrt_chk
   import smbalrt_pkg::*;
#(
   parameter int                FLT_W    = 16,
   parameter int                ADDR_W   = 7,
   parameter logic [ADDR_W-1:0] ARA_ADDR = 7'b0001100
) (
   input logic              clk,
   input logic              rst_n,
   input logic [FLT_W-1:0]  fault_in,
   input logic [FLT_W-1:0]  en_vec,
   input logic              pending,
   input logic              release_req,
   input logic              alert_n,
   input logic              sda_pull,
   input logic              sda_in,
   input logic              ev_start,
   input logic              ev_stop,
   input logic              ev_addr_valid,
   input logic              ev_sda_sample,
   input logic [ADDR_W:0]   addr_byte,
   input ara_st_e           st
);
   // R1
   no_enabled_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((fault_in & en_vec) == '0) |-> alert_n);
   // R4
   ara_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && ev_addr_valid && addr_byte == {ARA_ADDR, 1'b1} && !pending
       && !ev_start && !ev_stop) |=> !sda_pull);
   // R6
   arb_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SEND && ev_sda_sample && !sda_pull && !sda_in && !ev_start && !ev_stop)
      |=> (!sda_pull && !alert_n == pending && st == ST_LOST));
   // R7
   win_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      release_req |=> (alert_n || ((fault_in & en_vec & ~$past(fault_in & en_vec)) != '0)));
   // R8
   persist_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alert_n |=> (alert_n || !$stable(fault_in) || !$stable(en_vec)));
   // R10
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_start || ev_stop) |=> !sda_pull);
endmodule

bind smb_alert_responder smbalrt_chk #(.FLT_W(FLT_W), .ADDR_W(ADDR_W), .ARA_ADDR(ARA_ADDR)) u_chk (
   .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .en_vec(en_vec), .pending(pending),
   .release_req(release_req), .alert_n(alert_n), .sda_pull(sda_pull), .sda_in(sda_in),
   .ev_start(ev_start), .ev_stop(ev_stop), .ev_addr_valid(ev_addr_valid),
   .ev_sda_sample(ev_sda_sample), .addr_byte(addr_byte), .st(ara_state)
);

// File: tb/smb_alert_responder_tb.sv
module smb_alert_responder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] fault_in = '0;
   logic [1:0]  en_wr = '0;
   logic [7:0]  en_wdata = '0;
   logic        rel_on_addr = 1'b0;
   logic [6:0]  dev_addr = 7'h2A;
   logic        ev_start = 0, ev_stop = 0, ev_addr_valid = 0, ev_tx_slot = 0, ev_sda_sample = 0;
   logic [7:0]  addr_byte = '0;
   logic        other_pull = 1'b0;
   wire         sda_in;
   wire         alert_n, sda_pull;

   int n_cmp = 0, n_bad = 0;
   string cur_req = "R2";
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz

   assign sda_in = ~(sda_pull | other_pull);

   smb_alert_responder u_dut (
      .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .en_wr(en_wr), .en_wdata(en_wdata),
      .rel_on_addr(rel_on_addr), .dev_addr(dev_addr), .ev_start(ev_start), .ev_stop(ev_stop),
      .ev_addr_valid(ev_addr_valid), .addr_byte(addr_byte), .ev_tx_slot(ev_tx_slot),
      .ev_sda_sample(ev_sda_sample), .sda_in(sda_in), .alert_n(alert_n), .sda_pull(sda_pull)
   );

   // behavioural reference: phase 0 idle,1 armed,2 ack,3 send,4 lost,5 done
   int          m_ph = 0, m_k = 0;
   logic [15:0] m_en = '0, m_rep = '0, m_act;
   bit          m_rel, sda_s = 1'b1;

   function automatic bit m_bit(int k);
      return (k < 7) ? dev_addr[6-k] : 1'b1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_k = 0; m_en = '0; m_rep = '0;
      end else begin
         m_act = fault_in & m_en;
         m_rel = 0;
         if (ev_start || ev_stop) m_ph = 0;
         else if (m_ph == 0) begin
            if (ev_addr_valid) begin
               if (addr_byte == 8'h19 && (m_act & ~m_rep) != 0) m_ph = 1;
               if (rel_on_addr && addr_byte[7:1] == dev_addr) m_rel = 1;
            end
         end else if (m_ph == 1) begin
            if (ev_tx_slot) m_ph = 2;
         end else if (m_ph == 2) begin
            if (ev_tx_slot) begin m_ph = 3; m_k = 0; end
         end else if (m_ph == 3) begin
            if (ev_sda_sample) begin
               if (m_bit(m_k) && !sda_s) m_ph = 4;
               else if (m_k == 7) begin m_ph = 5; m_rel = 1; end
            end else if (ev_tx_slot) m_k++;
         end
         m_rep = m_rel ? m_act : (m_rep & m_act);
         if (en_wr[0]) m_en[7:0]  = en_wdata;
         if (en_wr[1]) m_en[15:8] = en_wdata;
      end
   end

   task automatic chk(string req, string what, logic act, logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      sda_s = sda_in;
      if (rst_n && !done) begin
         chk(cur_req, "alert_n", alert_n, ((fault_in & m_en & ~m_rep) == 0));
         chk(cur_req, "sda_pull", sda_pull, (m_ph == 2) || (m_ph == 3 && !m_bit(m_k)));
      end
   end

   task automatic step(); @(posedge clk); #2; endtask
   task automatic step_n(int n); for (int i = 0; i < n; i++) step(); endtask
   task automatic p_start(); ev_start = 1; step(); ev_start = 0; endtask
   task automatic p_stop();  ev_stop = 1;  step(); ev_stop = 0;  endtask
   task automatic p_addr(logic [7:0] b); addr_byte = b; ev_addr_valid = 1; step(); ev_addr_valid = 0; endtask
   task automatic p_tx();    ev_tx_slot = 1; step(); ev_tx_slot = 0; endtask
   task automatic p_smp();   ev_sda_sample = 1; step(); ev_sda_sample = 0; endtask
   task automatic wr_en(int k, logic [7:0] d); en_wdata = d; en_wr[k] = 1'b1; step(); en_wr = '0; endtask

   bit ack_seen;
   task automatic ara_run(logic [6:0] rival, bit rival_on);
      p_start();
      p_addr(8'h19);
      p_tx(); #6 ack_seen = sda_pull; step();
      p_smp(); step();
      for (int b = 0; b < 8; b++) begin
         other_pull = rival_on && ((b < 7) ? !rival[6-b] : 1'b0);
         p_tx(); step(); p_smp(); step();
      end
      other_pull = 1'b0;
      p_tx(); p_smp(); p_stop(); step();
   endtask

   initial begin
      step_n(3);
      rst_n = 1'b1;
      #6;
      chk("R2", "reset alert_n", alert_n, 1'b1);
      chk("R2", "reset sda_pull", sda_pull, 1'b0);
      step();

      cur_req = "R1"; fault_in = 16'h0001; step_n(2);
      chk("R1", "masked fault", alert_n, 1'b1);
      cur_req = "R3"; wr_en(0, 8'h01); step();
      chk("R3", "enabled fault", alert_n, 1'b0);

      cur_req = "R5"; ara_run(7'h00, 0);
      chk("R4", "ack when pending", ack_seen, 1'b1);
      chk("R7", "released after win", alert_n, 1'b1);

      cur_req = "R8"; step_n(5);
      chk("R8", "persistent fault silent", alert_n, 1'b1);
      wr_en(1, 8'h80); fault_in = 16'h8001; step();
      chk("R8", "new bit asserts", alert_n, 1'b0);
      ara_run(7'h00, 0);
      chk("R7", "second release", alert_n, 1'b1);
      fault_in = 16'h8000; step(); fault_in = 16'h8001; step();
      chk("R8", "clear then set asserts", alert_n, 1'b0);

      cur_req = "R6"; ara_run(7'h11, 1);
      chk("R6", "lost keeps alert", alert_n, 1'b0);

      cur_req = "R9"; p_start(); p_addr({dev_addr, 1'b0}); p_stop(); step();
      chk("R9", "no release when option off", alert_n, 1'b0);
      rel_on_addr = 1'b1; p_start(); p_addr({dev_addr, 1'b1}); p_stop(); step();
      chk("R9", "release on own address", alert_n, 1'b1);
      rel_on_addr = 1'b0;

      cur_req = "R4"; ara_run(7'h00, 0);
      chk("R4", "no ack without pending", ack_seen, 1'b0);

      cur_req = "R10"; fault_in = 16'h0001; step(); fault_in = 16'h8001; step();
      p_start(); p_addr(8'h19); p_tx();
      chk("R10", "ack before abort", sda_pull, 1'b1);
      p_stop(); #6;
      chk("R10", "released after stop", sda_pull, 1'b0);
      step_n(3);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule